// File: doc/BRIEF.md
# Line-Blank Table DMA Sequencer

This block drives eight table-driven DMA channels, each of which moves a few bytes to a fixed destination page once per video line. A frame-start pulse prepares the channels for a new frame. For each enabled channel it points the running table address at that channel's table base and reads the first line-counter byte. Each line-blank pulse then starts one line pass, which has two phases. In the first phase, every channel that is due delivers its bytes. In the second phase, every live channel steps its line counter and, when a counter runs out, fetches the next counter byte from its table.

All memory traffic goes through a single valid/ready request port with at most one access outstanding. A requester raises `mem_valid` with the address, the direction and the write data. It holds all of them steady, whatever `mem_ready` does, until the cycle in which `mem_ready` is high. Read data comes back later on `mem_rvalid`, which the block accepts unconditionally. The block reports the master-cycle cost of frame preparation as a one-cycle charge pulse. At the end of each line pass it arms a short counter that tells the CPU to hold off interrupt sampling.

Top module: `hdma_sched`

## Requirements
- R1: After reset `busy`, `mem_valid`, `cyc_chg_valid`, `irq_hold`, `ch_pending` and `ch_finished` are all zero.
- R2: A frame-start pulse clears the pending and finished flags of all eight channels. If the enable mask is zero at that time, the block issues no charge and no memory access.
- R3: A frame-start pulse with a nonzero mask produces exactly one `cyc_chg_valid` pulse with `cyc_chg_amt` = 18. It also sets the pending flag of all eight channels, disabled ones included.
- R4: During frame preparation, enabled channels are handled in ascending index order. Each one copies its table base into its running address and reads its counter byte at that address, then advances the address by one. Counter bit 7 is the repeat flag and bits 6:0 are the line count. A counter byte of zero sets the channel's finished flag.
- R5: On a line-blank pulse with a nonzero mask, phase one runs first, visiting channels in ascending order. For each enabled, unfinished, pending channel it reads a byte at the running address, advances the address, and writes that byte to address {8'h21, dest + offset}. Every phase-one write precedes every phase-two read.
- R6: A channel that is disabled or finished is skipped in both phases. It makes no memory access, and its pending and finished flags keep their values.
- R7: Mode field (2 bits per channel): 0 moves 1 byte at offset 0; 1 moves 2 bytes at offsets 0,1; 2 moves 2 bytes both at offset 0; 3 moves 4 bytes at offsets 0,1,2,3.
- R8: In phase two, each enabled, unfinished channel decrements its count, and its pending flag takes the repeat bit. If the count becomes zero, the channel reads a new counter byte at its running address and forces its pending flag to 1. A zero byte read there marks the channel finished.
- R9: A line-blank pulse with a zero mask is ignored: `busy` stays low, no access is made, and `irq_hold` is unchanged.
- R10: In the cycle after `busy` falls, `irq_hold` reads 2. It then drops by one on each `insn_done` cycle and stops at 0.
- R11: While `mem_valid` is high and `mem_ready` is low, the request stays asserted with stable address, direction and data. Only one read is outstanding at a time.
- R12: `busy` is high from the cycle after the line-blank pulse until phase two has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame-start pulse |
| line_blank | input | 1 | Line-blank pulse |
| en_mask | input | 8 | Channel enable, bit i = channel i |
| ch_mode | input | 16 | Transfer mode, 2 bits per channel |
| ch_table | input | 128 | Table base address, 16 bits per channel |
| ch_dest | input | 64 | Destination offset in page 8'h21, 8 bits per channel |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Line pass in progress |
| cyc_chg_valid | output | 1 | Master-cycle charge pulse |
| cyc_chg_amt | output | 6 | Charged master cycles |
| insn_done | input | 1 | CPU retired one instruction |
| irq_hold | output | 2 | Interrupt-sampling hold count |
| ch_pending | output | 8 | Per-channel pending flags |
| ch_finished | output | 8 | Per-channel finished flags |

## Verification
The bench goes after the ordering of the two phases. With two live channels, it checks that both data writes land before either counter reload. A design that reloads each channel straight after that channel's transfer would interleave the reads and fail the check.

Disabled channels must end frame preparation pending. A design that marks only the enabled channels would show 8'h01 instead of 8'hFF.

A counter that runs out and reloads zero must leave its channel finished, and later lines must then make no access for it. A design that skips the finished test would keep fetching table bytes.

A zero mask must leave the block idle on both pulses, while still clearing the flags on frame start. Across all four modes, the write offsets must match the mode table. A design that mixes up modes 1 and 2 would write the second byte to the wrong address.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_INIT_SCAN,
    S_INIT_REQ,
    S_INIT_WAIT,
    S_P1_SCAN,
    S_P1_RREQ,
    S_P1_RWAIT,
    S_P1_WREQ,
    S_P2_SCAN,
    S_P2_REQ,
    S_P2_WAIT,
    S_DONE
  } seq_state_e;

  // bytes moved per line for a mode
  function automatic logic [2:0] xfer_len(input logic [1:0] mode);
    case (mode)
      2'd0:    xfer_len = 3'd1;
      2'd1:    xfer_len = 3'd2;
      2'd2:    xfer_len = 3'd2;
      default: xfer_len = 3'd4;
    endcase
  endfunction

  // destination offset of byte k for a mode
  function automatic logic [1:0] port_off(input logic [1:0] mode, input logic [1:0] k);
    case (mode)
      2'd1, 2'd3: port_off = k;
      default:    port_off = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/hdma_chan_state.sv
module hdma_chan_state #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_flags,
  input  logic          set_pend,
  input  logic          sel,
  input  logic          addr_load,
  input  logic [AW-1:0] base,
  input  logic          addr_inc,
  input  logic          cnt_load,
  input  logic [7:0]    cnt_in,
  input  logic          cnt_dec,
  output logic [AW-1:0] cur_addr,
  output logic          last_line,
  output logic          done,
  output logic          pend
);

  logic [7:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (clr_flags) begin
        done <= 1'b0;
        pend <= 1'b0;
      end
      if (set_pend) pend <= 1'b1;
      if (sel) begin
        if (addr_load)     cur_addr <= base;
        else if (addr_inc) cur_addr <= cur_addr + 1'b1;
        if (cnt_load) begin
          cnt  <= cnt_in;
          done <= (cnt_in == 8'd0);
          pend <= 1'b1;
        end else if (cnt_dec) begin
          cnt[6:0] <= cnt[6:0] - 7'd1;
          pend     <= cnt[7];
        end
      end
    end
  end

  assign last_line = (cnt[6:0] == 7'd1);

  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr_flags |=> $stable(cur_addr)); // R6

endmodule

// File: rtl/hdma_seq.sv
module hdma_seq
  import hdma_pkg::*;
#(
  parameter int            NCH       = 8,
  parameter int            AW        = 16,
  parameter int            CHG_W     = 6,
  parameter int            INIT_CYC  = 18,
  parameter logic [AW-9:0] DEST_PAGE = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_blank,
  input  logic [NCH-1:0]    en_mask,
  input  logic [2*NCH-1:0]  mode_flat,
  input  logic [8*NCH-1:0]  dest_flat,
  input  logic [AW*NCH-1:0] addr_flat,
  input  logic [NCH-1:0]    last_v,
  input  logic [NCH-1:0]    done_v,
  input  logic [NCH-1:0]    pend_v,
  output logic              clr_flags,
  output logic              set_pend,
  output logic [NCH-1:0]    sel,
  output logic              addr_load,
  output logic              addr_inc,
  output logic              cnt_load,
  output logic [7:0]        cnt_in,
  output logic              cnt_dec,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              line_end,
  output logic              cyc_chg_valid,
  output logic [CHG_W-1:0]  cyc_chg_amt
);

  localparam int            CHW  = $clog2(NCH);
  localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

  seq_state_e     st;
  logic [CHW-1:0] ch;
  logic [NCH-1:0] mask_q;
  logic [1:0]     k;
  logic [7:0]     hold_q;

  logic [AW-1:0] c_addr;
  logic [7:0]    c_dest;
  logic [1:0]    c_mode;
  logic [2:0]    c_len;
  logic [1:0]    c_off;
  logic          c_elig;
  logic          c_last;

  always_comb begin
    c_addr = addr_flat[ch*AW +: AW];
    c_dest = dest_flat[ch*8 +: 8];
    c_mode = mode_flat[ch*2 +: 2];
    c_len  = xfer_len(c_mode);
    c_off  = port_off(c_mode, k);
    c_elig = mask_q[ch] && !done_v[ch];
    c_last = (ch == LAST);
  end

  always_comb begin
    sel       = '0;
    sel[ch]   = 1'b1;
    clr_flags = (st == S_IDLE) && frame_start;
    set_pend  = clr_flags && (|en_mask);
    addr_load = (st == S_INIT_SCAN) && mask_q[ch];
    mem_valid = (st == S_INIT_REQ) || (st == S_P1_RREQ) ||
                (st == S_P1_WREQ) || (st == S_P2_REQ);
    mem_we    = (st == S_P1_WREQ);
    mem_addr  = mem_we ? {DEST_PAGE, c_dest + 8'(c_off)} : c_addr;
    mem_wdata = hold_q;
    addr_inc  = mem_valid && mem_ready && !mem_we;
    cnt_load  = mem_rvalid && ((st == S_INIT_WAIT) || (st == S_P2_WAIT));
    cnt_in    = mem_rdata;
    cnt_dec   = (st == S_P2_SCAN) && c_elig;
    busy      = (st == S_P1_SCAN) || (st == S_P1_RREQ) || (st == S_P1_RWAIT) ||
                (st == S_P1_WREQ) || (st == S_P2_SCAN) || (st == S_P2_REQ) ||
                (st == S_P2_WAIT) || (st == S_DONE);
    line_end  = (st == S_DONE);
  end

  assign cyc_chg_amt = CHG_W'(INIT_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      ch            <= '0;
      mask_q        <= '0;
      k             <= '0;
      hold_q        <= '0;
      cyc_chg_valid <= 1'b0;
    end else begin
      cyc_chg_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (frame_start) begin
            mask_q <= en_mask;
            ch     <= '0;
            if (|en_mask) begin
              cyc_chg_valid <= 1'b1;
              st            <= S_INIT_SCAN;
            end
          end else if (line_blank && (|en_mask)) begin
            mask_q <= en_mask;
            ch     <= '0;
            st     <= S_P1_SCAN;
          end
        end
        S_INIT_SCAN: begin
          if (mask_q[ch]) st <= S_INIT_REQ;
          else if (c_last) st <= S_IDLE;
          else ch <= ch + 1'b1;
        end
        S_INIT_REQ: if (mem_ready) st <= S_INIT_WAIT;
        S_INIT_WAIT: begin
          if (mem_rvalid) begin
            if (c_last) st <= S_IDLE;
            else begin
              ch <= ch + 1'b1;
              st <= S_INIT_SCAN;
            end
          end
        end
        S_P1_SCAN: begin
          if (c_elig && pend_v[ch]) begin
            k  <= '0;
            st <= S_P1_RREQ;
          end else if (c_last) begin
            ch <= '0;
            st <= S_P2_SCAN;
          end else ch <= ch + 1'b1;
        end
        S_P1_RREQ: if (mem_ready) st <= S_P1_RWAIT;
        S_P1_RWAIT: begin
          if (mem_rvalid) begin
            hold_q <= mem_rdata;
            st     <= S_P1_WREQ;
          end
        end
        S_P1_WREQ: begin
          if (mem_ready) begin
            if ({1'b0, k} == c_len - 3'd1) begin
              if (c_last) begin
                ch <= '0;
                st <= S_P2_SCAN;
              end else begin
                ch <= ch + 1'b1;
                st <= S_P1_SCAN;
              end
            end else begin
              k  <= k + 2'd1;
              st <= S_P1_RREQ;
            end
          end
        end
        S_P2_SCAN: begin
          if (c_elig && last_v[ch]) st <= S_P2_REQ;
          else if (c_last) st <= S_DONE;
          else ch <= ch + 1'b1;
        end
        S_P2_REQ: if (mem_ready) st <= S_P2_WAIT;
        S_P2_WAIT: begin
          if (mem_rvalid) begin
            if (c_last) st <= S_DONE;
            else begin
              ch <= ch + 1'b1;
              st <= S_P2_SCAN;
            end
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11

  AST_WRITE_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> busy); // R5

  AST_CHARGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_chg_valid |-> $past(frame_start) && ($past(en_mask) != '0)); // R3

endmodule

// File: rtl/hdma_sched.sv
module hdma_sched #(
  parameter int NCH   = 8,
  parameter int AW    = 16,
  parameter int CHG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_blank,
  input  logic [NCH-1:0]    en_mask,
  input  logic [2*NCH-1:0]  ch_mode,
  input  logic [AW*NCH-1:0] ch_table,
  input  logic [8*NCH-1:0]  ch_dest,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              cyc_chg_valid,
  output logic [CHG_W-1:0]  cyc_chg_amt,
  input  logic              insn_done,
  output logic [1:0]        irq_hold,
  output logic [NCH-1:0]    ch_pending,
  output logic [NCH-1:0]    ch_finished
);

  logic              clr_flags, set_pend, addr_load, addr_inc;
  logic              cnt_load, cnt_dec, line_end;
  logic [7:0]        cnt_in;
  logic [NCH-1:0]    sel, last_v;
  logic [AW*NCH-1:0] addr_flat;

  hdma_seq #(.NCH(NCH), .AW(AW), .CHG_W(CHG_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .line_blank(line_blank), .en_mask(en_mask),
    .mode_flat(ch_mode), .dest_flat(ch_dest), .addr_flat(addr_flat),
    .last_v(last_v), .done_v(ch_finished), .pend_v(ch_pending),
    .clr_flags(clr_flags), .set_pend(set_pend), .sel(sel),
    .addr_load(addr_load), .addr_inc(addr_inc),
    .cnt_load(cnt_load), .cnt_in(cnt_in), .cnt_dec(cnt_dec),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .line_end(line_end),
    .cyc_chg_valid(cyc_chg_valid), .cyc_chg_amt(cyc_chg_amt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hdma_chan_state #(.AW(AW)) u_state (
      .clk(clk), .rst_n(rst_n),
      .clr_flags(clr_flags), .set_pend(set_pend), .sel(sel[g]),
      .addr_load(addr_load), .base(ch_table[g*AW +: AW]), .addr_inc(addr_inc),
      .cnt_load(cnt_load), .cnt_in(cnt_in), .cnt_dec(cnt_dec),
      .cur_addr(addr_flat[g*AW +: AW]), .last_line(last_v[g]),
      .done(ch_finished[g]), .pend(ch_pending[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       irq_hold <= 2'd0;
    else if (line_end)                irq_hold <= 2'd2;
    else if (insn_done && irq_hold != 2'd0) irq_hold <= irq_hold - 2'd1;
  end

  AST_HOLD_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_hold == 2'd2); // R10

  AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$fell(busy) && $past(irq_hold) != 2'd3 |-> irq_hold <= $past(irq_hold)); // R10

endmodule

// File: tb/test_hdma_sched.sv
module test_hdma_sched;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_start = 1'b0, line_blank = 1'b0, insn_done = 1'b0;
  logic [7:0]   en_mask = '0;
  logic [15:0]  ch_mode = '0;
  logic [127:0] ch_table = '0;
  logic [63:0]  ch_dest = '0;
  logic         mem_valid, mem_we, busy, cyc_chg_valid;
  logic         mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [15:0]  mem_addr;
  logic [7:0]   mem_wdata, mem_rdata = '0;
  logic [5:0]   cyc_chg_amt;
  logic [1:0]   irq_hold;
  logic [7:0]   ch_pending, ch_finished;

  always #5 clk = ~clk;

  hdma_sched i_hdma_sched (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_blank(line_blank),
    .en_mask(en_mask), .ch_mode(ch_mode), .ch_table(ch_table), .ch_dest(ch_dest),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(busy), .cyc_chg_valid(cyc_chg_valid),
    .cyc_chg_amt(cyc_chg_amt), .insn_done(insn_done), .irq_hold(irq_hold),
    .ch_pending(ch_pending), .ch_finished(ch_finished)
  );

  // memory model: stalls every fourth cycle, read data one cycle after accept
  logic [7:0]  mem [0:255];
  logic [7:0]  tick = '0;
  int          log_n = 0, chg_n = 0;
  logic [5:0]  chg_amt = '0;
  logic        log_we   [0:255];
  logic [15:0] log_addr [0:255];
  logic [7:0]  log_data [0:255];

  always @(posedge clk) begin
    tick      <= tick + 8'd1;
    mem_ready <= (tick[1:0] != 2'd3);
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      log_we[log_n[7:0]]   <= mem_we;
      log_addr[log_n[7:0]] <= mem_addr;
      log_data[log_n[7:0]] <= mem_we ? mem_wdata : mem[mem_addr[7:0]];
      log_n <= log_n + 1;
      if (!mem_we) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[7:0]];
      end
    end
    if (cyc_chg_valid) begin
      chg_n   <= chg_n + 1;
      chg_amt <= cyc_chg_amt;
    end
  end

  int n_chk = 0, n_fail = 0;
  logic busy_seen;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic run_line();
    @(negedge clk) line_blank = 1'b1;
    @(negedge clk) line_blank = 1'b0;
    busy_seen = busy;
    for (int g = 0; g < 2000 && busy; g++) @(negedge clk);
    @(negedge clk);
  endtask

  // {mode[1:0], counter byte[7:0], bytes[2:0], pending after line, finished after line}
  localparam logic [14:0] VEC [5] = '{
    {2'd0, 8'h03, 3'd1, 1'b0, 1'b0},
    {2'd1, 8'h83, 3'd2, 1'b1, 1'b0},
    {2'd2, 8'h05, 3'd2, 1'b0, 1'b0},
    {2'd3, 8'h82, 3'd4, 1'b1, 1'b0},
    {2'd0, 8'h01, 3'd1, 1'b1, 1'b1}
  };

  // {write, address} expected for the two-channel line
  localparam logic [16:0] EXP_F [6] = '{
    {1'b0, 16'h0041}, {1'b1, 16'h2110}, {1'b0, 16'h0061},
    {1'b1, 16'h2120}, {1'b0, 16'h0042}, {1'b0, 16'h0062}
  };

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] m;
    logic [7:0] c;
    logic [2:0] n;
    logic       ep, ed;
    int         s, c0, idx;
    logic [7:0] off;

    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "mem_valid", mem_valid, 0);
    chk("R1", "charge", cyc_chg_valid, 0);
    chk("R1", "irq_hold", irq_hold, 0);
    chk("R1", "pending", ch_pending, 0);
    chk("R1", "finished", ch_finished, 0);

    for (int v = 0; v < 5; v++) begin
      m = VEC[v][14:13]; c = VEC[v][12:5]; n = VEC[v][4:2]; ep = VEC[v][1]; ed = VEC[v][0];
      en_mask = 8'h01; ch_mode = 16'(m);
      ch_table = '0; ch_table[15:0] = 16'h0010;
      ch_dest = '0; ch_dest[7:0] = 8'h18;
      mem[8'h10] = c;
      for (int k = 0; k < int'(n); k++) mem[8'h11 + k] = 8'hA0 + 8'(v * 8 + k);
      mem[8'h11 + n] = 8'h00;
      c0 = chg_n; s = log_n;
      pulse_frame();
      chk("R3", "charge pulses", chg_n - c0, 1);
      chk("R3", "charge amount", chg_amt, 18);
      chk("R3", "all pending after frame", ch_pending, 8'hFF);
      chk("R4", "first read at base", log_addr[s[7:0]], 16'h0010);
      chk("R4", "nonzero counter not finished", ch_finished, 0);
      s = log_n;
      run_line();
      chk("R12", "busy after line pulse", busy_seen, 1);
      for (int k = 0; k < int'(n); k++) begin
        idx = s + 2 * k;
        off = (m == 2'd1 || m == 2'd3) ? 8'(k) : 8'd0;
        chk("R5", "data read addr", {log_we[idx[7:0]], log_addr[idx[7:0]]}, {1'b0, 16'h0011 + 16'(k)});
        chk("R7", "write addr", {log_we[idx[7:0] + 8'd1], log_addr[idx[7:0] + 8'd1]}, {1'b1, 16'h2100 | 16'(8'h18 + off)});
        chk("R5", "write data", log_data[idx[7:0] + 8'd1], mem[8'h11 + k]);
      end
      chk("R8", "access count", log_n - s, 2 * int'(n) + int'(ed));
      chk("R8", "pending after line", ch_pending, {7'h7F, ep});
      chk("R8", "finished after line", ch_finished, {7'h00, ed});
      chk("R10", "irq_hold after line", irq_hold, 2);
    end

    // finished channel is skipped
    s = log_n;
    run_line();
    chk("R6", "no access for finished channel", log_n - s, 0);
    chk("R6", "finished kept", ch_finished, 8'h01);
    chk("R6", "pending kept", ch_pending, 8'hFF);

    // interrupt hold countdown
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk);
    chk("R10", "hold after one insn", irq_hold, 1);
    @(negedge clk);
    chk("R10", "hold after two insns", irq_hold, 0);
    @(negedge clk);
    chk("R10", "hold floors at zero", irq_hold, 0);
    insn_done = 1'b0;

    // zero mask at frame start
    en_mask = 8'h00; c0 = chg_n; s = log_n;
    pulse_frame();
    chk("R2", "pending cleared", ch_pending, 0);
    chk("R2", "finished cleared", ch_finished, 0);
    chk("R2", "no charge", chg_n - c0, 0);
    chk("R2", "no access", log_n - s, 0);

    // zero mask at line blank
    @(negedge clk) line_blank = 1'b1;
    @(negedge clk) line_blank = 1'b0;
    chk("R9", "busy stays low", busy, 0);
    repeat (5) @(negedge clk);
    chk("R9", "no access", log_n - s, 0);
    chk("R9", "irq_hold unchanged", irq_hold, 0);

    // three channels: ordering, zero counter at init, two-phase line
    en_mask = 8'h07; ch_mode = '0; ch_table = '0; ch_dest = '0;
    ch_table[15:0] = 16'h0040; ch_table[31:16] = 16'h0050; ch_table[47:32] = 16'h0060;
    ch_dest[7:0] = 8'h10; ch_dest[23:16] = 8'h20;
    mem[8'h40] = 8'h01; mem[8'h41] = 8'h55; mem[8'h42] = 8'h00;
    mem[8'h50] = 8'h00;
    mem[8'h60] = 8'h01; mem[8'h61] = 8'h66; mem[8'h62] = 8'h00;
    s = log_n;
    pulse_frame();
    chk("R4", "init access count", log_n - s, 3);
    chk("R4", "init order ch0", log_addr[s[7:0]], 16'h0040);
    chk("R4", "init order ch1", log_addr[s[7:0] + 8'd1], 16'h0050);
    chk("R4", "init order ch2", log_addr[s[7:0] + 8'd2], 16'h0060);
    chk("R4", "zero counter finishes", ch_finished, 8'h02);
    chk("R3", "pending incl disabled", ch_pending, 8'hFF);
    s = log_n;
    run_line();
    chk("R5", "line access count", log_n - s, 6);
    for (int i = 0; i < 6; i++)
      chk("R5", "phase order", {log_we[s[7:0] + 8'(i)], log_addr[s[7:0] + 8'(i)]}, EXP_F[i]);
    chk("R5", "ch0 data", log_data[s[7:0] + 8'd1], 8'h55);
    chk("R5", "ch2 data", log_data[s[7:0] + 8'd3], 8'h66);
    chk("R8", "all live channels finished", ch_finished, 8'h07);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule